// File: doc/BRIEF.md
# Decode-Once Pipeline Control with Delay-Slot Squash

This block is the control path of a five-stage in-order pipeline. Each instruction is decoded once, in the decode stage. The resulting control word then travels with the instruction through the execute, memory and writeback pipeline registers. Every stage reads only its own slice of that word: operand and ALU controls in execute, the store and branch flags in memory, and the result select and register-write enable in writeback. The register file, ALU and memories live outside the block and take these outputs as their control inputs.

Each branch has one architectural delay slot. The equality test happens in decode. Its result is registered, and the fetch redirect (`pc_sel`) is requested while the branch is in execute. The instruction that follows the branch sequentially is the delay slot, and it executes. By the time `pc_sel` is high, a second sequential instruction has already been fetched. That instruction is captured into decode with its valid bit cleared, so it moves down the pipe as a no-op.

A stall freezes the fetch and decode registers and inserts a bubble into execute. A flush discards whatever is in decode, inserts a bubble into execute and cancels any pending redirect. Every stage carries a valid bit.

Top module: `dsc_pipe_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_sel`, all stage valid bits and all control outputs are 0.
- R2: Opcode 0 is a register op whose funct selects the ALU operation: 0 add, 1 sub, 2 and, 3 or. The remaining opcodes are: 1 add-immediate, 2 or-immediate, 3 load, 4 store, 5 branch-if-equal. ALU op codes are add=0, sub=1, and=2, or=3. A valid decoded instruction that issues shows its execute group one cycle later on `ex_ext_sign`, `ex_alu_imm`, `ex_alu_op` and `ex_ovf_en`, with `ex_valid`=1.
- R3: The memory group (`mem_wr`, `mem_branch`) of an instruction appears exactly two cycles after it leaves decode, and the writeback group (`wb_mem_to_reg`, `wb_reg_wr`) appears exactly three cycles after. The stage valid bits follow the same timing.
- R4: If decode holds no valid instruction, execute receives a bubble: `ex_valid`=0 and all execute, memory and writeback controls are 0 as the bubble travels.
- R5: A valid branch-if-equal in decode with `regs_equal`=1, no stall and no flush raises `pc_sel` on the next cycle. A branch with `regs_equal`=0 does not raise it.
- R6: The delay-slot instruction keeps its valid bit. The instruction captured into decode on a cycle where `pc_sel`=1 and there is no stall gets `dec_valid`=0, and it reaches execute as a no-op with no overflow enable and no register write.
- R7: While `stall`=1 and `flush`=0, `dec_valid` and `pc_sel` hold their values and execute receives a bubble. The memory and writeback stages keep advancing.
- R8: `flush`=1 clears `dec_valid` and `pc_sel` on the next cycle and sends a bubble to execute. It takes priority over `stall`.
- R9: An undefined opcode (6 or 7), or a register op with a funct above 3, issues with `ex_valid`=1 but with every control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch stage holds a real instruction |
| opcode | input | OPC_W | Opcode of the instruction in decode |
| funct | input | FN_W | Function field of the instruction in decode |
| regs_equal | input | 1 | The two decode-stage register reads are equal |
| stall | input | 1 | Hold fetch and decode, insert a bubble into execute |
| flush | input | 1 | Kill decode and the pending redirect |
| pc_sel | output | 1 | Select the branch target for the next fetch |
| dec_valid | output | 1 | Decode stage valid |
| ex_valid | output | 1 | Execute stage valid |
| ex_ext_sign | output | 1 | Sign-extend the immediate (0: zero-extend) |
| ex_alu_imm | output | 1 | ALU second operand is the immediate |
| ex_alu_op | output | 2 | ALU operation |
| ex_ovf_en | output | 1 | Overflow trap enabled |
| mem_valid | output | 1 | Memory stage valid |
| mem_wr | output | 1 | Data memory write |
| mem_branch | output | 1 | Instruction in memory is a branch |
| wb_valid | output | 1 | Writeback stage valid |
| wb_mem_to_reg | output | 1 | Write back memory data instead of the ALU result |
| wb_reg_wr | output | 1 | Register file write enable |

## Verification
The assertions assume that `opcode`, `funct` and `regs_equal` describe the instruction held in decode. Only the valid bits and the stall/flush pair decide whether that instruction moves on. They also assume that stall and flush are sampled at the same edge as the rest, with no hold timing across the edge. The stimulus changes every input only on the falling clock edge. It draws opcodes and functs over their full ranges, undefined codes included. It raises stall and flush at independent rates, so every combination, a flush during a stall among them, occurs. Directed sequences place a taken branch, its delay slot and the squashed shadow instruction back to back, including one case with a stall during the pending redirect.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    ext_sign;
    logic    alu_imm;
    alu_op_e alu_op;
    logic    ovf_en;
  } ex_grp_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_grp_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int WB_W   = $bits(wb_grp_t);
  localparam int MW_W   = $bits(mem_grp_t) + WB_W;

  localparam int OP_REG   = 0;
  localparam int OP_ADDI  = 1;
  localparam int OP_ORI   = 2;
  localparam int OP_LOAD  = 3;
  localparam int OP_STORE = 4;
  localparam int OP_BEQ   = 5;

  localparam int FN_ADD = 0;
  localparam int FN_SUB = 1;
  localparam int FN_AND = 2;
  localparam int FN_OR  = 3;

endpackage

// File: rtl/dsc_decoder.sv
module dsc_decoder
  import dsc_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctrl_t            ctrl,
  output logic             is_branch
);

  always_comb begin
    ctrl      = '0;
    is_branch = 1'b0;
    case (opcode)
      OPC_W'(OP_REG): begin
        case (funct)
          FN_W'(FN_ADD): begin ctrl.ex.alu_op = ALU_ADD; ctrl.ex.ovf_en = 1'b1; ctrl.wb.reg_wr = 1'b1; end
          FN_W'(FN_SUB): begin ctrl.ex.alu_op = ALU_SUB; ctrl.ex.ovf_en = 1'b1; ctrl.wb.reg_wr = 1'b1; end
          FN_W'(FN_AND): begin ctrl.ex.alu_op = ALU_AND; ctrl.wb.reg_wr = 1'b1; end
          FN_W'(FN_OR):  begin ctrl.ex.alu_op = ALU_OR;  ctrl.wb.reg_wr = 1'b1; end
          default: ctrl = '0;
        endcase
      end
      OPC_W'(OP_ADDI): begin
        ctrl.ex.ext_sign = 1'b1;
        ctrl.ex.alu_imm  = 1'b1;
        ctrl.ex.alu_op   = ALU_ADD;
        ctrl.ex.ovf_en   = 1'b1;
        ctrl.wb.reg_wr   = 1'b1;
      end
      OPC_W'(OP_ORI): begin
        ctrl.ex.alu_imm = 1'b1;
        ctrl.ex.alu_op  = ALU_OR;
        ctrl.wb.reg_wr  = 1'b1;
      end
      OPC_W'(OP_LOAD): begin
        ctrl.ex.ext_sign  = 1'b1;
        ctrl.ex.alu_imm   = 1'b1;
        ctrl.ex.alu_op    = ALU_ADD;
        ctrl.wb.mem_to_reg = 1'b1;
        ctrl.wb.reg_wr    = 1'b1;
      end
      OPC_W'(OP_STORE): begin
        ctrl.ex.ext_sign = 1'b1;
        ctrl.ex.alu_imm  = 1'b1;
        ctrl.ex.alu_op   = ALU_ADD;
        ctrl.mem.mem_wr  = 1'b1;
      end
      OPC_W'(OP_BEQ): begin
        ctrl.ex.alu_op  = ALU_SUB;
        ctrl.mem.branch = 1'b1;
        is_branch       = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/dsc_shadow.sv
module dsc_shadow (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_valid,
  input  logic stall,
  input  logic flush,
  input  logic branch_dec,
  input  logic regs_equal,
  output logic dec_valid,
  output logic pc_sel,
  output logic issue
);

  logic dec_valid_q, dec_valid_d;
  logic redir_q, redir_d;
  logic taken;

  assign issue = dec_valid_q & ~stall & ~flush;
  assign taken = issue & branch_dec & regs_equal;

  always_comb begin
    if (flush) begin
      dec_valid_d = 1'b0;
      redir_d     = 1'b0;
    end else if (stall) begin
      dec_valid_d = dec_valid_q;
      redir_d     = redir_q;
    end else begin
      dec_valid_d = fetch_valid & ~redir_q;
      redir_d     = taken;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q <= 1'b0;
      redir_q     <= 1'b0;
    end else begin
      dec_valid_q <= dec_valid_d;
      redir_q     <= redir_d;
    end
  end

  assign dec_valid = dec_valid_q;
  assign pc_sel    = redir_q;

  AST_SHADOW_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel && !stall) |=> !dec_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(dec_valid) && $stable(pc_sel))); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!dec_valid && !pc_sel)); // R8

endmodule

// File: rtl/dsc_stage_reg.sv
module dsc_stage_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vin,
  input  logic [W-1:0] d,
  output logic         vq,
  output logic [W-1:0] q
);

  logic         v_d;
  logic [W-1:0] q_d;

  always_comb begin
    v_d = vin;
    q_d = vin ? d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= 1'b0;
      q  <= '0;
    end else begin
      vq <= v_d;
      q  <= q_d;
    end
  end

endmodule

// File: rtl/dsc_pipe_ctrl.sv
module dsc_pipe_ctrl
  import dsc_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             regs_equal,
  input  logic             stall,
  input  logic             flush,
  output logic             pc_sel,
  output logic             dec_valid,
  output logic             ex_valid,
  output logic             ex_ext_sign,
  output logic             ex_alu_imm,
  output logic [1:0]       ex_alu_op,
  output logic             ex_ovf_en,
  output logic             mem_valid,
  output logic             mem_wr,
  output logic             mem_branch,
  output logic             wb_valid,
  output logic             wb_mem_to_reg,
  output logic             wb_reg_wr
);

  ctrl_t             dec_ctrl;
  logic              dec_branch;
  logic              issue;
  logic [CTRL_W-1:0] ex_bits;
  ctrl_t             ex_ctrl;
  logic [MW_W-1:0]   mem_bits;
  logic [WB_W-1:0]   wb_bits;
  mem_grp_t          mem_grp;
  wb_grp_t           wb_grp;

  dsc_decoder #(.OPC_W(OPC_W), .FN_W(FN_W)) u_dec (
    .opcode    (opcode),
    .funct     (funct),
    .ctrl      (dec_ctrl),
    .is_branch (dec_branch)
  );

  dsc_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .stall       (stall),
    .flush       (flush),
    .branch_dec  (dec_branch),
    .regs_equal  (regs_equal),
    .dec_valid   (dec_valid),
    .pc_sel      (pc_sel),
    .issue       (issue)
  );

  dsc_stage_reg #(.W(CTRL_W)) u_ex_reg (
    .clk (clk), .rst_n (rst_n),
    .vin (issue), .d (dec_ctrl),
    .vq  (ex_valid), .q (ex_bits)
  );

  assign ex_ctrl = ctrl_t'(ex_bits);

  dsc_stage_reg #(.W(MW_W)) u_mem_reg (
    .clk (clk), .rst_n (rst_n),
    .vin (ex_valid), .d ({ex_ctrl.mem, ex_ctrl.wb}),
    .vq  (mem_valid), .q (mem_bits)
  );

  assign mem_grp = mem_grp_t'(mem_bits[MW_W-1:WB_W]);

  dsc_stage_reg #(.W(WB_W)) u_wb_reg (
    .clk (clk), .rst_n (rst_n),
    .vin (mem_valid), .d (mem_bits[WB_W-1:0]),
    .vq  (wb_valid), .q (wb_bits)
  );

  assign wb_grp = wb_grp_t'(wb_bits);

  assign ex_ext_sign   = ex_ctrl.ex.ext_sign;
  assign ex_alu_imm    = ex_ctrl.ex.alu_imm;
  assign ex_alu_op     = ex_ctrl.ex.alu_op;
  assign ex_ovf_en     = ex_ctrl.ex.ovf_en;
  assign mem_wr        = mem_grp.mem_wr;
  assign mem_branch    = mem_grp.branch;
  assign wb_mem_to_reg = wb_grp.mem_to_reg;
  assign wb_reg_wr     = wb_grp.reg_wr;

  AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mem_valid == $past(ex_valid)) && (wb_valid == $past(mem_valid)))); // R3
  AST_EX_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || flush) |=> (!ex_valid && !ex_ovf_en && !ex_alu_imm)); // R7
  AST_REDIRECT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_sel) |-> (ex_valid && ex_ctrl.mem.branch)); // R5
  AST_WB_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wb_reg_wr == $past(mem_bits[0]))); // R3

endmodule

// File: tb/tb_dsc_pipe_ctrl.sv
module tb_dsc_pipe_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fetch_valid, regs_equal, stall, flush;
  logic [5:0] opcode, funct;
  logic       pc_sel, dec_valid, ex_valid, ex_ext_sign, ex_alu_imm, ex_ovf_en;
  logic [1:0] ex_alu_op;
  logic       mem_valid, mem_wr, mem_branch, wb_valid, wb_mem_to_reg, wb_reg_wr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  logic       m_dv, m_pend, m_exv, m_memv, m_wbv;
  logic [8:0] m_ex;
  logic [3:0] m_mem;
  logic [1:0] m_wb;

  always #10 clk = ~clk;

  dsc_pipe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .opcode(opcode), .funct(funct),
    .regs_equal(regs_equal), .stall(stall), .flush(flush), .pc_sel(pc_sel),
    .dec_valid(dec_valid), .ex_valid(ex_valid), .ex_ext_sign(ex_ext_sign),
    .ex_alu_imm(ex_alu_imm), .ex_alu_op(ex_alu_op), .ex_ovf_en(ex_ovf_en),
    .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_branch(mem_branch),
    .wb_valid(wb_valid), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr)
  );

  // {ext_sign, alu_imm, alu_op[1:0], ovf_en, mem_wr, branch, mem_to_reg, reg_wr}
  function automatic logic [8:0] exp_bundle(input logic [5:0] opc, input logic [5:0] fn);
    case (opc)
      6'd0: case (fn)
              6'd0: return 9'b0_0_00_1_00_01;
              6'd1: return 9'b0_0_01_1_00_01;
              6'd2: return 9'b0_0_10_0_00_01;
              6'd3: return 9'b0_0_11_0_00_01;
              default: return 9'b0;
            endcase
      6'd1: return 9'b1_1_00_1_00_01;
      6'd2: return 9'b0_1_11_0_00_01;
      6'd3: return 9'b1_1_00_0_00_11;
      6'd4: return 9'b1_1_00_0_10_00;
      6'd5: return 9'b0_0_01_0_01_00;
      default: return 9'b0;
    endcase
  endfunction

  function automatic logic [13:0] exp_vec();
    return {m_pend, m_dv, m_exv, m_ex[8:4], m_memv, m_mem[3:2], m_wbv, m_wb};
  endfunction

  function automatic logic [13:0] act_vec();
    return {pc_sel, dec_valid, ex_valid, ex_ext_sign, ex_alu_imm, ex_alu_op, ex_ovf_en,
            mem_valid, mem_wr, mem_branch, wb_valid, wb_mem_to_reg, wb_reg_wr};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dv = 0; m_pend = 0; m_exv = 0; m_memv = 0; m_wbv = 0;
    m_ex = '0; m_mem = '0; m_wb = '0;
  endtask

  // drive one cycle at the falling edge, advance the model, compare one cycle later
  task automatic step(input logic fv, input logic [5:0] opc, input logic [5:0] fn,
                      input logic eq, input logic st, input logic fl, input string tag);
    logic       n_dv, n_pend, n_exv, issue;
    logic [8:0] n_ex;
    fetch_valid = fv; opcode = opc; funct = fn; regs_equal = eq; stall = st; flush = fl;
    issue  = m_dv & ~st & ~fl;
    n_exv  = issue;
    n_ex   = issue ? exp_bundle(opc, fn) : 9'b0;
    if (fl) begin n_dv = 0; n_pend = 0; end
    else if (st) begin n_dv = m_dv; n_pend = m_pend; end
    else begin n_dv = fv & ~m_pend; n_pend = issue & (opc == 6'd5) & eq; end
    @(negedge clk);
    m_wbv  = m_memv; m_wb = m_mem[1:0];
    m_memv = m_exv;  m_mem = m_ex[3:0];
    m_exv  = n_exv;  m_ex = n_ex;
    m_dv   = n_dv;   m_pend = n_pend;
    check(act_vec() === exp_vec(), tag, act_vec(), exp_vec());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; fetch_valid = 0; opcode = '0; funct = '0; regs_equal = 0; stall = 0; flush = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(act_vec() === 14'b0, "R1", act_vec(), 14'b0);
    rst_n = 1;
    @(negedge clk);
    check(act_vec() === 14'b0, "R1", act_vec(), 14'b0);

    // R2 / R3: every defined instruction through the pipe
    step(1, 6'd0, 6'd0, 0, 0, 0, "R2");
    for (int o = 0; o < 6; o++) step(1, 6'(o), 6'd1, 0, 0, 0, "R2");
    step(1, 6'd0, 6'd2, 0, 0, 0, "R3");
    step(1, 6'd0, 6'd3, 0, 0, 0, "R3");
    step(1, 6'd3, 6'd0, 0, 0, 0, "R3");
    // R9: undefined codes
    step(1, 6'd7, 6'd0, 0, 0, 0, "R9");
    step(1, 6'd0, 6'd9, 0, 0, 0, "R9");
    step(1, 6'd6, 6'd0, 1, 0, 0, "R9");
    // R5 / R6: taken branch, delay slot, squashed shadow
    step(1, 6'd5, 6'd0, 1, 0, 0, "R5");
    if (pc_sel !== 1'b1) check(0, "R5", {13'b0, pc_sel}, 14'b1);
    step(1, 6'd2, 6'd0, 0, 0, 0, "R6");
    if (dec_valid !== 1'b0) check(0, "R6", {13'b0, dec_valid}, 14'b0);
    step(1, 6'd1, 6'd0, 0, 0, 0, "R6");
    step(1, 6'd1, 6'd0, 0, 0, 0, "R4");
    // R5: not-taken branch
    step(1, 6'd5, 6'd0, 0, 0, 0, "R5");
    step(1, 6'd0, 6'd0, 0, 0, 0, "R5");
    // R7: stall while redirect pending
    step(1, 6'd5, 6'd0, 1, 0, 0, "R7");
    step(1, 6'd1, 6'd0, 0, 1, 0, "R7");
    step(1, 6'd1, 6'd0, 0, 1, 0, "R7");
    step(1, 6'd1, 6'd0, 0, 0, 0, "R6");
    step(1, 6'd1, 6'd0, 0, 0, 0, "R4");
    // R8: flush with stall, flush of a pending redirect
    step(1, 6'd5, 6'd0, 1, 0, 0, "R8");
    step(1, 6'd3, 6'd0, 0, 1, 1, "R8");
    step(0, 6'd3, 6'd0, 0, 0, 0, "R4");
    step(0, 6'd3, 6'd0, 0, 0, 0, "R4");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic fv, eq, st, fl;
      logic [5:0] opc, fn;
      fv  = ($urandom % 100) < 85;
      eq  = $urandom % 2;
      st  = ($urandom % 100) < 15;
      fl  = ($urandom % 100) < 5;
      opc = 6'($urandom % 8);
      fn  = ($urandom % 10 == 0) ? 6'($urandom % 64) : 6'($urandom % 5);
      step(fv, opc, fn, eq, st, fl, "R2");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule